// File: doc/BRIEF.md
# Phase-Offset Amplitude-Scaled Direct Digital Synthesizer

This block generates a periodic 10-bit unsigned waveform, one sample per clock. A 32-bit phase accumulator advances by a frequency tuning word on every clock and wraps freely. The upper ten bits of the accumulated phase are shifted by a phase offset word to form the address of a 1024-entry sine table. The selected sample is then scaled by an amplitude word, and a fixed ten-bit window of the product drives the output.

The three control words are plain level inputs. They are sampled on every rising clock edge. There is no load strobe and no handshake. The output is a free-running stream with no valid or ready qualifier, and the block cannot be back-pressured: a new sample appears on every clock.

The latency is fixed. A change of the phase offset word or the amplitude word reaches the output two clock edges after the edge that samples it. A change of the tuning word reaches the output three edges after the edge that samples it.

Reset is synchronous and active high. It clears the accumulator and every pipeline register.

Top module: `dds_synth`

## Requirements
- R1: On every clock edge at which `rst` is high, the accumulator, the table address register and the output register clear to zero. `wave_o` reads 0 after such an edge.
- R2: On each edge with `rst` low, the phase accumulator adds `tune_i` and wraps modulo 2^32. A tuning word of 0xFFFFFFFF therefore steps the phase backwards by one.
- R3: The table address is (accumulator bits 31..22 + `phase_ofs_i`) modulo 1024. The lower 22 accumulator bits are discarded without rounding.
- R4: Table entry k (k = 0..1023) holds round(511.5 + 511.5·sin(2πk/1024)), with halves rounded up. Entry 0 is 512, entry 1 is 515, entry 256 is 1023 and entry 768 is 0.
- R5: The output equals bits 18..9 of the 20-bit unsigned product of table sample and amplitude word. Bit 19 is dropped, so sample 1023 times amplitude 1023 gives 1020. With amplitude 512 the output equals the table sample.
- R6: A change of `phase_ofs_i` or `amp_i` appears on `wave_o` after exactly two rising edges. A change of `tune_i` appears after exactly three.
- R7: Whenever the amplitude word in effect is 0, `wave_o` is 0 whatever the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tune_i | input | 32 | Frequency tuning word added to the phase every clock |
| phase_ofs_i | input | 10 | Phase offset added to the truncated table address |
| amp_i | input | 10 | Unsigned amplitude multiplier |
| wave_o | output | 10 | Scaled waveform sample, one per clock |

## Verification
The bench sweeps the phase offset across all 1024 addresses with unit amplitude (512), so any mis-rounded or shifted table entry shows up directly. A design that slices the wrong product bits, or saturates instead of wrapping, would give something other than 1020 for full-scale sample times full-scale amplitude. A pipeline that is one register short or one register long is caught by stepping each control word and sampling the output just before and just after the expected edge. Tuning words of 0xFFFFFFFF and of values just under one address step test the wrap and the truncation; a design that rounds the phase, or keeps carries out of bit 31, would drift from the reference stream.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Offset-binary sine code for one table index, half-up rounding.
  function automatic int sine_code(int idx, int addr_w, int samp_w);
    real half;
    real ang;
    half = ((2.0 ** samp_w) - 1.0) / 2.0;
    ang  = 2.0 * 3.14159265358979323846 * real'(idx) / (2.0 ** addr_w);
    return $rtoi(half + half * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  step_i,
  output logic [ADDR_W-1:0] phase_top_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + step_i;
  end

  assign phase_top_o = acc_q[ACC_W-1 -: ADDR_W];
endmodule

// File: rtl/dds_offset_add.sv
module dds_offset_add #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] phase_i,
  input  logic [ADDR_W-1:0] offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) addr_o <= '0;
    else     addr_o <= phase_i + offset_i;
  end
endmodule

// File: rtl/dds_wave_rom.sv
module dds_wave_rom #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SAMP_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      mem[k] = SAMP_W'(dds_pkg::sine_code(k, ADDR_W, SAMP_W));
    end
  end

  assign data_o = mem[addr_i];
endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int SAMP_W  = 10,
  parameter int AMP_W   = 10,
  parameter int OUT_LSB = 9,
  parameter int OUT_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [OUT_W-1:0]  out_o
);
  localparam int PROD_W = SAMP_W + AMP_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(samp_i) * PROD_W'(amp_i);
  end

  always_ff @(posedge clk) begin
    if (rst) out_o <= '0;
    else     out_o <= OUT_W'(prod >> OUT_LSB);
  end
endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 10,
  parameter int AMP_W   = 10,
  parameter int OUT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  tune_i,
  input  logic [ADDR_W-1:0] phase_ofs_i,
  input  logic [AMP_W-1:0]  amp_i,
  output logic [SAMP_W-1:0] wave_o
);
  logic [ADDR_W-1:0] phase_top;
  logic [ADDR_W-1:0] addr_q;
  logic [SAMP_W-1:0] samp;
  logic [AMP_W-1:0]  amp_q;

  dds_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .step_i(tune_i), .phase_top_o(phase_top)
  );

  dds_offset_add #(.ADDR_W(ADDR_W)) u_ofs (
    .clk(clk), .rst(rst), .phase_i(phase_top), .offset_i(phase_ofs_i),
    .addr_o(addr_q)
  );

  // Amplitude is staged alongside the address so both reach the multiplier together.
  always_ff @(posedge clk) begin
    if (rst) amp_q <= '0;
    else     amp_q <= amp_i;
  end

  dds_wave_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .addr_i(addr_q), .data_o(samp)
  );

  dds_amp_scale #(
    .SAMP_W(SAMP_W), .AMP_W(AMP_W), .OUT_LSB(OUT_LSB), .OUT_W(SAMP_W)
  ) u_scale (
    .clk(clk), .rst(rst), .samp_i(samp), .amp_i(amp_q), .out_o(wave_o)
  );
endmodule

// File: rtl/dds_synth_chk.sv
module dds_synth_chk #(
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 10,
  parameter int AMP_W   = 10,
  parameter int OUT_LSB = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [ACC_W-1:0]  tune_i,
  input logic [ADDR_W-1:0] phase_ofs_i,
  input logic [AMP_W-1:0]  amp_i,
  input logic [SAMP_W-1:0] wave_o,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [AMP_W-1:0]  amp_q,
  input logic [SAMP_W-1:0] samp
);
  localparam int PROD_W = SAMP_W + AMP_W;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0 && addr_q == '0 && wave_o == '0));

  p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_q == ACC_W'($past(acc_q) + $past(tune_i)));

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      addr_q == ADDR_W'($past(acc_q[ACC_W-1 -: ADDR_W]) + $past(phase_ofs_i)));

  p_out_slice_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      wave_o == SAMP_W'((PROD_W'($past(samp)) * PROD_W'($past(amp_q))) >> OUT_LSB));

  p_amp_align_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> amp_q == $past(amp_i));

  p_zero_amp_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amp_q) == '0) |-> wave_o == '0);
endmodule

bind dds_synth dds_synth_chk #(
  .ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .AMP_W(AMP_W), .OUT_LSB(OUT_LSB)
) u_chk (
  .clk(clk), .rst(rst), .tune_i(tune_i), .phase_ofs_i(phase_ofs_i), .amp_i(amp_i),
  .wave_o(wave_o), .acc_q(u_acc.acc_q), .addr_q(addr_q), .amp_q(amp_q), .samp(samp)
);

// File: tb/dds_synth_tb.sv
`timescale 1ns/1ps
module dds_synth_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tune = '0;
  logic [9:0]  ofs = '0;
  logic [9:0]  amp = '0;
  logic [9:0]  wave;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dds_synth u_dut (
    .clk(clk), .rst(rst), .tune_i(tune), .phase_ofs_i(ofs), .amp_i(amp), .wave_o(wave)
  );

  // Independent expected table and scaling
  logic [9:0] tbl [1024];
  initial begin
    for (int k = 0; k < 1024; k++)
      tbl[k] = 10'(int'(511.5 + 511.5 * $sin(2.0 * 3.141592653589793 * k / 1024.0)));
  end

  function automatic logic [9:0] scale(logic [9:0] s, logic [9:0] a);
    logic [19:0] p;
    p = {10'd0, s} * {10'd0, a};
    return p[18:9];
  endfunction

  // Reference stream: three stages for the tuning word, two for offset and amplitude
  logic [31:0] m_acc;
  logic [9:0]  m_addr, m_amp, m_out;
  always @(posedge clk) begin
    if (rst) begin
      m_acc <= '0; m_addr <= '0; m_amp <= '0; m_out <= '0;
    end else begin
      m_acc  <= m_acc + tune;
      m_addr <= m_acc[31:22] + ofs;
      m_amp  <= amp;
      m_out  <= scale(tbl[m_addr], m_amp);
    end
  end

  task automatic check(string req, logic [9:0] exp);
    checks++;
    if (wave !== exp) begin
      errors++;
      $display("FAIL %s: wave_o=%0d expected=%0d at %0t", req, wave, exp, $time);
    end
  endtask

  task automatic do_reset(logic [31:0] t, logic [9:0] o, logic [9:0] a);
    @(negedge clk);
    rst = 1'b1; tune = t; ofs = o; amp = a;
    @(negedge clk);
    check("R1 output cleared in reset", 10'd0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_model(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, m_out);
    end
  endtask

  task automatic t_reset();
    do_reset(32'd0, 10'd0, 10'd512);
    @(negedge clk);
    check("R1 first cycle after reset", 10'd0);
    @(negedge clk);
    check("R1 cleared accumulator reads entry 0", 10'd512);
  endtask

  task automatic t_table_sweep();
    do_reset(32'd0, 10'd0, 10'd512);
    for (int k = 0; k < 1024; k++) begin
      @(negedge clk); ofs = 10'(k);
      @(negedge clk);
      @(negedge clk);
      check("R4 table entry", tbl[k]);
    end
    ofs = 10'd0;   @(negedge clk); @(negedge clk); @(negedge clk); check("R4 entry 0", 10'd512);
    ofs = 10'd1;   @(negedge clk); @(negedge clk); check("R4 entry 1", 10'd515);
    ofs = 10'd256; @(negedge clk); @(negedge clk); check("R4 entry 256", 10'd1023);
    ofs = 10'd768; @(negedge clk); @(negedge clk); check("R4 entry 768", 10'd0);
  endtask

  task automatic t_latency();
    do_reset(32'd0, 10'd0, 10'd512);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R6 steady before offset step", 10'd512);
    ofs = 10'd256;
    @(negedge clk); check("R6 offset not yet visible after 1 edge", 10'd512);
    @(negedge clk); check("R6 offset visible after 2 edges", 10'd1023);
    amp = 10'd0;
    @(negedge clk); check("R6 amplitude not yet visible after 1 edge", 10'd1023);
    @(negedge clk); check("R6 amplitude visible after 2 edges", 10'd0);
    do_reset(32'd0, 10'd0, 10'd512);
    @(negedge clk); @(negedge clk); @(negedge clk);
    tune = 32'h0040_0000;
    @(negedge clk); check("R6 tuning not visible after 1 edge", 10'd512);
    tune = 32'd0;
    @(negedge clk); check("R6 tuning not visible after 2 edges", 10'd512);
    @(negedge clk); check("R6 tuning visible after 3 edges", 10'd515);
  endtask

  task automatic t_freq_runs();
    do_reset(32'h0040_0000, 10'd0, 10'd512);
    run_model("R2 unit address step", 200);
    tune = 32'h003F_FFFF;
    run_model("R3 truncation just under one step", 300);
    tune = 32'hFFFF_FFFF;
    run_model("R2 wrap with all-ones tuning word", 200);
    tune = 32'hFFC0_0000;
    run_model("R2 backwards step", 200);
    tune = 32'h1234_5678; ofs = 10'd700; amp = 10'd777;
    run_model("R3 offset wrap with odd tuning word", 300);
  endtask

  task automatic t_amp();
    do_reset(32'd0, 10'd256, 10'd1023);
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R5 full scale product drops bit 19", 10'd1020);
    amp = 10'd1;
    @(negedge clk); @(negedge clk);
    check("R5 amplitude 1 on sample 1023", 10'd1);
    tune = 32'h0123_4567; amp = 10'd0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      check("R7 zero amplitude gives zero", 10'd0);
    end
    amp = 10'd333;
    run_model("R5 general amplitude", 200);
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    tune = 32'h0765_4321; ofs = 10'd100; amp = 10'd900;
    run_model("R5 running before reset", 50);
    rst = 1'b1;
    @(negedge clk); check("R1 mid-run reset clears output", 10'd0);
    @(negedge clk); check("R1 held reset", 10'd0);
    rst = 1'b0;
    run_model("R1 restart after reset", 100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_table_sweep();
    t_latency();
    t_freq_runs();
    t_amp();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule